// File: doc/BRIEF.md
# Request-Acknowledge Pairing Monitor

This block watches a request line and its acknowledge line and confirms that each request receives an acknowledge within a bounded number of clock cycles. It is a synthesizable checker. It can sit in front of an interrupt masking stage or beside any request and response pair. From the end of reset until operation stops, it keeps track of every request that is still waiting. Up to four requests can wait at the same time, and each one has its own age counter. Acknowledges retire the waiting requests oldest first.

The monitor raises a failure in three cases:
- A request that receives no acknowledge in time is a timeout.
- An acknowledge that arrives when nothing is waiting is spurious.
- A request that arrives when every tracking slot is full is an overflow.

Each failure produces a one-cycle pulse and advances a saturating failure count. It also sets a sticky flag that stays set until reset. Separate saturating counts record the requests and the acknowledges. A check-enable input silences the failure reporting and freezes the counts, while request tracking keeps running. A debug-enable input exposes the number of waiting requests.

Top module: `rapm_monitor`

## Requirements
- R1: Driving `rst_n` low clears, at once and without waiting for a clock edge, all tracking state, every count, every pulse, the sticky flag and the pending view.
- R2: An acknowledge sampled 1, 2, 3, 4 or 5 rising edges after the request's edge retires that request without a failure. While `chk_en` is high, every sampled request adds one to `req_count`, and every sampled acknowledge adds one to `ack_count`.
- R3: Suppose a request sees no acknowledge by its 5th edge after the request edge. After that 5th edge, `err_timeout` is high for one cycle, `fail_count` rises by one and the request is dropped.
- R4: An acknowledge sampled on the same edge as a request never retires that request. It retires an older waiting request if there is one, otherwise it counts as spurious. The new request keeps waiting either way.
- R5: Suppose an acknowledge is sampled while no request is waiting. After that edge, `err_spurious` is high for one cycle and `fail_count` rises by one.
- R6: Up to 4 requests may wait at the same time, and each acknowledge retires the oldest waiting request.
- R7: Suppose a request is sampled while 4 requests are still waiting after that edge's retirement. The request is dropped, `err_overflow` pulses for one cycle, and `fail_count` rises by one.
- R8: While `chk_en` is low, no failure pulse is raised, the sticky flag is not set, and all three counts hold their values. Requests are still tracked and timed.
- R9: `err_sticky` goes high together with the first enabled failure pulse and stays high until reset.
- R10: `dbg_pending` shows the number of waiting requests while `dbg_en` is high and reads 0 while `dbg_en` is low.
- R11: Each count stops at its all-ones value and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Request pulse being monitored |
| ack | input | 1 | Acknowledge being monitored |
| chk_en | input | 1 | Enables failure reporting and counting |
| dbg_en | input | 1 | Enables the pending-request view |
| err_timeout | output | 1 | One-cycle pulse: a request went unanswered |
| err_spurious | output | 1 | One-cycle pulse: acknowledge with nothing waiting |
| err_overflow | output | 1 | One-cycle pulse: request dropped, tracker full |
| err_sticky | output | 1 | Set by any reported failure, cleared by reset |
| req_count | output | CNT_W | Saturating count of sampled requests |
| ack_count | output | CNT_W | Saturating count of sampled acknowledges |
| fail_count | output | CNT_W | Saturating count of reported failures |
| dbg_pending | output | $clog2(MAX_OUT+1) | Waiting requests, 0 when debug is off |

## Verification
The assertions check several invariants on every cycle:
- The occupancy register always equals the number of valid slots, and the valid slots stay packed at the head.
- No stored age exceeds the window.
- At most one kind of failure occurs per edge, and every failure pulse is matched by a one-step rise of the failure count or by a saturated count.
- The sticky flag never falls, and nothing is reported or counted while checking is off.

Only the bench scenarios can show that the window edges fall at exactly 1 and 5 cycles, and that an acknowledge on the request's own edge is not accepted. The same holds for oldest-first retirement, for the fifth overlapping request being dropped, for late acknowledges turning into spurious ones, and for the counts stopping at all ones.

// File: rtl/rapm_pkg.sv
// Shared types for the request-acknowledge pairing monitor.
// Assumes: one event record is produced per clock edge by the tracker.
package rapm_pkg;

    // Outcome of one clock edge as seen by the tracker.
    typedef struct packed {
        logic ack_hit;   // acknowledge retired the oldest waiting request
        logic timeout;   // oldest request ran out of window
        logic spurious;  // acknowledge with nothing waiting
        logic overflow;  // request dropped because all slots are busy
        logic push;      // request accepted into a slot
    } rapm_evt_t;

    // True when the edge produced any kind of failure.
    function automatic logic rapm_any_fail(rapm_evt_t e);
        return e.timeout | e.spurious | e.overflow;
    endfunction

endpackage

// File: rtl/rapm_age_slot.sv
// One tracking slot: holds a valid bit and the age of one waiting request.
// Each edge the slot either takes its upper neighbour (when the queue
// shifts), keeps its own entry, or loads a fresh request at age 0.
// A held entry ages by one per edge.
// Assumes: the tracker retires an entry before its age passes AGE_LIM.
module rapm_age_slot #(
    parameter int AGE_W   = 3,
    parameter int AGE_LIM = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_up,
    input  logic             up_vld,
    input  logic [AGE_W-1:0] up_age,
    input  logic             load_new,
    output logic             vld,
    output logic [AGE_W-1:0] age
);

    logic             src_vld;
    logic [AGE_W-1:0] src_age;
    logic             nxt_vld;
    logic [AGE_W-1:0] nxt_age;

    // Choose the entry this slot holds after the edge.
    always_comb begin
        src_vld = take_up ? up_vld : vld;
        src_age = take_up ? up_age : age;
        if (load_new) begin
            nxt_vld = 1'b1;
            nxt_age = '0;
        end else if (src_vld) begin
            nxt_vld = 1'b1;
            nxt_age = src_age + AGE_W'(1);
        end else begin
            nxt_vld = 1'b0;
            nxt_age = '0;
        end
    end

    // Slot storage with asynchronous clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld <= 1'b0;
            age <= '0;
        end else begin
            vld <= nxt_vld;
            age <= nxt_age;
        end
    end

    assert_age_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> (age <= AGE_W'(AGE_LIM)));

    assert_new_entry_fresh_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load_new |=> (vld && age == '0));

endmodule

// File: rtl/rapm_tracker.sv
// Tracks the waiting requests in a shift queue of age slots; slot 0 is the oldest.
// On each edge:
//   - an acknowledge retires slot 0;
//   - slot 0 times out when it reaches the last edge of its window unanswered;
//   - a request enters at the first free slot once the retirement is applied.
// Assumes: the request is a single-cycle pulse. An acknowledge on the request's
// own edge can never match that request, because the request is stored after
// the edge has been evaluated.
module rapm_tracker
    import rapm_pkg::*;
#(
    parameter int MAX_OUT = 4,
    parameter int WIN_MAX = 5,
    localparam int OCC_W  = $clog2(MAX_OUT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             ack,
    output rapm_evt_t        evt,
    output logic [OCC_W-1:0] occ
);

    localparam int AGE_W   = (WIN_MAX > 1) ? $clog2(WIN_MAX) : 1;
    localparam int AGE_LIM = WIN_MAX - 1;

    logic [MAX_OUT-1:0] vld;
    logic [AGE_W-1:0]   age [MAX_OUT];
    logic               pop;
    logic [OCC_W-1:0]   occ_post;

    // Classify the edge: retire, time out, spurious, overflow or accept.
    always_comb begin
        evt          = '0;
        evt.ack_hit  = ack & vld[0];
        evt.timeout  = vld[0] & ~ack & (age[0] == AGE_W'(AGE_LIM));
        evt.spurious = ack & ~vld[0];
        pop          = evt.ack_hit | evt.timeout;
        occ_post     = occ - OCC_W'(pop);
        evt.overflow = req & (occ_post == OCC_W'(MAX_OUT));
        evt.push     = req & ~evt.overflow;
    end

    // One age slot per allowed waiting request.
    for (genvar i = 0; i < MAX_OUT; i++) begin : g_slot
        logic             up_vld;
        logic [AGE_W-1:0] up_age;
        logic             load_new;

        if (i == MAX_OUT - 1) begin : g_top
            assign up_vld = 1'b0;
            assign up_age = '0;
        end else begin : g_mid
            assign up_vld = vld[i+1];
            assign up_age = age[i+1];
        end

        assign load_new = evt.push && (occ_post == OCC_W'(i));

        rapm_age_slot #(
            .AGE_W   (AGE_W),
            .AGE_LIM (AGE_LIM)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .take_up  (pop),
            .up_vld   (up_vld),
            .up_age   (up_age),
            .load_new (load_new),
            .vld      (vld[i]),
            .age      (age[i])
        );
    end

    // Occupancy register, kept alongside the slot valid bits.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ <= '0;
        end else begin
            occ <= occ_post + OCC_W'(evt.push);
        end
    end

    assert_occ_matches_slots_R6: assert property (@(posedge clk) disable iff (!rst_n)
        occ == OCC_W'($countones(vld)));

    assert_slots_packed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(vld + MAX_OUT'(1)));

    assert_occ_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OCC_W'(MAX_OUT));

    assert_single_failure_kind_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({evt.timeout, evt.spurious, evt.overflow}));

endmodule

// File: rtl/rapm_sat_counter.sv
// Saturating up-counter: adds one per pulse of inc and stops at all ones.
// Assumes: inc is already qualified by the check enable.
module rapm_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    // Count up, holding at the top value.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (inc && cnt != '1) begin
            cnt <= cnt + W'(1);
        end
    end

    assert_count_holds_at_top_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '1) |=> (cnt == '1));

    assert_count_idle_without_inc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(cnt));

endmodule

// File: rtl/rapm_counters.sv
// Bank of three saturating counters: requests, acknowledges and failures.
// Index 0 counts requests, 1 acknowledges, 2 failures.
// Assumes: en low must freeze every counter in the bank.
module rapm_counters #(
    parameter int CNT_W = 16,
    localparam int N_CNT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [N_CNT-1:0] inc,
    output logic [CNT_W-1:0] cnt [N_CNT]
);

    for (genvar k = 0; k < N_CNT; k++) begin : g_cnt
        logic inc_q;

        assign inc_q = en & inc[k];

        rapm_sat_counter #(
            .W (CNT_W)
        ) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (inc_q),
            .cnt   (cnt[k])
        );

        assert_frozen_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !en |=> $stable(cnt[k]));
    end

endmodule

// File: rtl/rapm_status.sv
// Registers the failure pulses, keeps the sticky failure flag, and gates
// the debug view of the pending-request count.
// Assumes: evt describes the edge currently being sampled.
module rapm_status
    import rapm_pkg::*;
#(
    parameter int OCC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             dbg_en,
    input  rapm_evt_t        evt,
    input  logic [OCC_W-1:0] occ,
    output logic             err_timeout,
    output logic             err_spurious,
    output logic             err_overflow,
    output logic             err_sticky,
    output logic [OCC_W-1:0] dbg_pending
);

    // One-cycle failure pulses and the flag that remembers them.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_timeout  <= 1'b0;
            err_spurious <= 1'b0;
            err_overflow <= 1'b0;
            err_sticky   <= 1'b0;
        end else begin
            err_timeout  <= en & evt.timeout;
            err_spurious <= en & evt.spurious;
            err_overflow <= en & evt.overflow;
            err_sticky   <= err_sticky | (en & rapm_any_fail(evt));
        end
    end

    // Debug view of the occupancy, zero when debug is off.
    always_comb begin
        dbg_pending = dbg_en ? occ : '0;
    end

    assert_sticky_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky);

    assert_pulse_implies_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_timeout || err_spurious || err_overflow) |-> err_sticky);

    assert_quiet_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !(err_timeout || err_spurious || err_overflow));

endmodule

// File: rtl/rapm_monitor.sv
// Request-acknowledge pairing monitor, top level.
// It joins three parts: the age-slot tracker, the status and pulse stage,
// and the counter bank.
// All outputs except dbg_pending are registered. dbg_pending follows dbg_en
// within the same cycle.
// Assumes: req is a single-cycle pulse. An acknowledge counts for a request
// only on edges 1 to WIN_MAX after the request's edge.
module rapm_monitor
    import rapm_pkg::*;
#(
    parameter int MAX_OUT = 4,
    parameter int WIN_MAX = 5,
    parameter int CNT_W   = 16,
    localparam int OCC_W  = $clog2(MAX_OUT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             ack,
    input  logic             chk_en,
    input  logic             dbg_en,
    output logic             err_timeout,
    output logic             err_spurious,
    output logic             err_overflow,
    output logic             err_sticky,
    output logic [CNT_W-1:0] req_count,
    output logic [CNT_W-1:0] ack_count,
    output logic [CNT_W-1:0] fail_count,
    output logic [OCC_W-1:0] dbg_pending
);

    rapm_evt_t        evt;
    logic [OCC_W-1:0] occ;
    logic [2:0]       cnt_inc;
    logic [CNT_W-1:0] cnt_val [3];

    rapm_tracker #(
        .MAX_OUT (MAX_OUT),
        .WIN_MAX (WIN_MAX)
    ) u_tracker (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .ack   (ack),
        .evt   (evt),
        .occ   (occ)
    );

    rapm_status #(
        .OCC_W (OCC_W)
    ) u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (chk_en),
        .dbg_en       (dbg_en),
        .evt          (evt),
        .occ          (occ),
        .err_timeout  (err_timeout),
        .err_spurious (err_spurious),
        .err_overflow (err_overflow),
        .err_sticky   (err_sticky),
        .dbg_pending  (dbg_pending)
    );

    // Counter increments: requests, acknowledges, failures.
    always_comb begin
        cnt_inc = {rapm_any_fail(evt), ack, req};
    end

    rapm_counters #(
        .CNT_W (CNT_W)
    ) u_counters (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (chk_en),
        .inc   (cnt_inc),
        .cnt   (cnt_val)
    );

    assign req_count  = cnt_val[0];
    assign ack_count  = cnt_val[1];
    assign fail_count = cnt_val[2];

    assert_fail_count_steps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (err_timeout || err_spurious || err_overflow) |->
            ((fail_count == $past(fail_count) + CNT_W'(1)) || ($past(fail_count) == '1)));

endmodule

// File: tb/rapm_monitor_tb.sv
// Scoreboard bench: the driver pushes the expected outputs for each edge,
// and a monitor pops them and compares at the following falling edge.
module rapm_monitor_tb;

    localparam int CW  = 4;
    localparam int MAXC = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic          ack = 1'b0;
    logic          chk_en = 1'b1;
    logic          dbg_en = 1'b1;
    logic          err_timeout, err_spurious, err_overflow, err_sticky;
    logic [CW-1:0] req_count, ack_count, fail_count;
    logic [2:0]    dbg_pending;

    always #4 clk = ~clk;

    rapm_monitor #(.MAX_OUT(4), .WIN_MAX(5), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .ack(ack),
        .chk_en(chk_en), .dbg_en(dbg_en),
        .err_timeout(err_timeout), .err_spurious(err_spurious),
        .err_overflow(err_overflow), .err_sticky(err_sticky),
        .req_count(req_count), .ack_count(ack_count),
        .fail_count(fail_count), .dbg_pending(dbg_pending)
    );

    typedef struct {
        string tag;
        int to, sp, ov, st, rc, ac, fc, pend;
    } exp_t;

    exp_t sbq[$];
    int   mq[$];
    int   m_rc, m_ac, m_fc, m_st;
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done = 0;

    function automatic int sat(int v);
        return (v > MAXC) ? MAXC : v;
    endfunction

    // Compare every observed output against one expected record.
    task automatic compare(exp_t e);
        int act [8];
        int exv [8];
        string nm [8];
        bit bad = 0;
        act = '{int'(err_timeout), int'(err_spurious), int'(err_overflow), int'(err_sticky),
                int'(req_count), int'(ack_count), int'(fail_count), int'(dbg_pending)};
        exv = '{e.to, e.sp, e.ov, e.st, e.rc, e.ac, e.fc, e.pend};
        nm  = '{"err_timeout", "err_spurious", "err_overflow", "err_sticky",
                "req_count", "ack_count", "fail_count", "dbg_pending"};
        n_vec++;
        for (int i = 0; i < 8; i++) begin
            if (act[i] != exv[i]) begin
                $display("FAIL %s %s actual=%0d expected=%0d at %0t", e.tag, nm[i], act[i], exv[i], $time);
                bad = 1;
            end
        end
        if (bad) n_bad++;
    endtask

    // Monitor: pop and compare at each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            if (sbq.size() > 0) compare(sbq.pop_front());
        end
    end

    // Apply one edge of stimulus and record what the requirements predict.
    task automatic cyc(input logic r, input logic a, input string tag);
        exp_t e;
        int   t, s, o;
        req = r;
        ack = a;
        t = (mq.size() > 0 && !a && mq[0] == 4) ? 1 : 0;
        s = (a && mq.size() == 0) ? 1 : 0;
        if (t == 1 || (a && mq.size() > 0)) void'(mq.pop_front());
        o = (r && mq.size() == 4) ? 1 : 0;
        foreach (mq[i]) mq[i]++;
        if (r && o == 0) mq.push_back(0);
        if (chk_en) begin
            m_rc = sat(m_rc + int'(r));
            m_ac = sat(m_ac + int'(a));
            m_fc = sat(m_fc + ((t | s | o) != 0 ? 1 : 0));
            if ((t | s | o) != 0) m_st = 1;
        end
        e.tag = tag;
        e.to = chk_en ? t : 0;
        e.sp = chk_en ? s : 0;
        e.ov = chk_en ? o : 0;
        e.st = m_st; e.rc = m_rc; e.ac = m_ac; e.fc = m_fc;
        e.pend = dbg_en ? mq.size() : 0;
        @(posedge clk);
        #1 sbq.push_back(e);
        @(negedge clk);
        req = 1'b0;
        ack = 1'b0;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, tag);
    endtask

    // Asynchronous reset: outputs must clear before any clock edge (R1).
    task automatic do_reset();
        exp_t z;
        #1 rst_n = 1'b0;
        #1;
        z.tag = "R1"; z.to = 0; z.sp = 0; z.ov = 0; z.st = 0;
        z.rc = 0; z.ac = 0; z.fc = 0; z.pend = 0;
        compare(z);
        mq.delete();
        m_rc = 0; m_ac = 0; m_fc = 0; m_st = 0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic set_ctl(input logic en, input logic dbg);
        #1;
        chk_en = en;
        dbg_en = dbg;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 20000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (2) @(negedge clk);
        do_reset();

        // R2: every delay inside the window is accepted.
        for (int d = 1; d <= 5; d++) begin
            cyc(1'b1, 1'b0, "R2");
            idle(d - 1, "R2");
            cyc(1'b0, 1'b1, "R2");
            idle(1, "R2");
        end

        // R3: no acknowledge by the 5th edge, then a late one is spurious (R5).
        cyc(1'b1, 1'b0, "R3");
        idle(5, "R3");
        idle(1, "R3");
        cyc(1'b0, 1'b1, "R5");
        idle(3, "R9");

        // R4: same-edge acknowledge never matches its own request.
        do_reset();
        cyc(1'b1, 1'b1, "R4");
        idle(1, "R4");
        cyc(1'b0, 1'b1, "R4");
        cyc(1'b1, 1'b0, "R4");
        cyc(1'b1, 1'b1, "R4");
        idle(1, "R4");
        cyc(1'b0, 1'b1, "R4");
        idle(5, "R4");

        // R5: bare acknowledge.
        cyc(1'b0, 1'b1, "R5");

        // R6: four overlapping requests retired oldest first.
        do_reset();
        for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, "R6");
        for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, "R6");
        cyc(1'b1, 1'b0, "R6");
        cyc(1'b1, 1'b0, "R6");
        idle(3, "R6");
        cyc(1'b0, 1'b1, "R6");
        idle(1, "R6");
        cyc(1'b0, 1'b1, "R6");
        idle(2, "R6");

        // R7: a fifth waiting request is dropped.
        do_reset();
        for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, "R7");
        idle(6, "R7");

        // R8: checking off, tracking continues silently.
        do_reset();
        set_ctl(1'b0, 1'b1);
        cyc(1'b1, 1'b0, "R8");
        idle(6, "R8");
        cyc(1'b0, 1'b1, "R8");
        cyc(1'b1, 1'b0, "R8");
        set_ctl(1'b1, 1'b1);
        cyc(1'b0, 1'b1, "R8");
        cyc(1'b0, 1'b1, "R8");
        idle(2, "R9");

        // R10: debug view gated by dbg_en.
        set_ctl(1'b1, 1'b0);
        cyc(1'b1, 1'b0, "R10");
        cyc(1'b1, 1'b0, "R10");
        set_ctl(1'b1, 1'b1);
        cyc(1'b0, 1'b0, "R10");
        cyc(1'b0, 1'b1, "R10");
        cyc(1'b0, 1'b1, "R10");

        // R11: counts stop at all ones.
        do_reset();
        for (int i = 0; i < 20; i++) begin
            cyc(1'b1, 1'b0, "R11");
            cyc(1'b0, 1'b1, "R11");
        end
        for (int i = 0; i < 20; i++) cyc(1'b0, 1'b1, "R11");
        idle(2, "R11");

        do_reset();
        @(negedge clk);
        finish_run();
    end

endmodule